// File: doc/BRIEF.md
# Load-Triggered Clock Divider Bank

The block derives four divided root clocks (UART, I2C, GMAC and SPI) from one functional input clock and gates ten peripheral instances off three of those roots. Each root has a programmable divisor and an enable. Each instance has its own enable bit in a shared peripheral register. Software programs everything through a simple word-addressed register port with a write strobe and a registered read path.

The block is built for FPGA use, so a divided clock is carried as a registered one-cycle clock-enable strobe in the input clock domain. A divisor of N gives one strobe every N input cycles. A divisor write alone only updates the visible shadow field. The running ratio changes only when software writes the same register again with the load bit set. That new ratio starts at the next period boundary of that root. Enable changes also wait for a period boundary, for the roots and for the instances, so no strobe is ever cut short or added mid-period.

Top module: `clkdiv_bank`

## Requirements
- R1: After a synchronous reset, every control register reads divisor 1 with enable 0, the peripheral enable register reads 0, and all root and instance strobes are low.
- R2: Control registers sit at 0x220 (UART root), 0x224 (I2C root), 0x228 (GMAC root) and 0x22C (SPI root). The divisor field is bits 11:8 and the enable is bit 0. A read returns the last written divisor and enable, with bit 16 always 0. Read data appears one cycle after the address.
- R3: An enabled root whose active divisor is N (1 to 15) raises its strobe for one cycle in every N input cycles.
- R4: An active divisor field of 0 behaves as divide-by-1.
- R5: A control write with bit 16 clear leaves the active division ratio unchanged.
- R6: A control write with bit 16 set loads that write's divisor field. The new ratio applies from the end of the root's current period.
- R7: A root whose enable is 0 keeps its strobe low. A change of enable takes effect only at that root's period boundary.
- R8: In the peripheral enable register at 0x270, bits 3:0 gate UART instances 0-3 from the UART root, bits 7:4 gate I2C instances 0-3 from the I2C root, and bits 9:8 gate SPI instances 0-1 from the SPI root. An enabled instance strobes exactly when its root strobes. Instance enable changes apply at the root's period boundary.
- R9: Reads of any other address return 0, and writes to any other address change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional input clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| root_tick | output | 4 | Root strobes: 0 UART, 1 I2C, 2 GMAC, 3 SPI |
| uart_tick | output | NUM_UART | UART instance strobes |
| i2c_tick | output | NUM_I2C | I2C instance strobes |
| spi_tick | output | NUM_SPI | SPI instance strobes |

## Verification
The checker enforces these on every cycle:
- No instance strobe fires without its parent root's strobe.
- Strobes are quiet in the cycle after reset.
- Unmapped addresses read as zero.
- A write followed by a read of the UART control register returns the written fields with the load bit clear.

Only the bench's scenarios can show the timing behaviour. Its reference model runs cycle by cycle and covers:
- the strobe spacing for each divisor, including 0 and 15;
- that a plain divisor write leaves the rate alone;
- that a loaded divisor or enable change waits for the period to end.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int ADDR_W     = 12;
  localparam int DATA_W     = 32;
  localparam int DIV_W      = 4;
  localparam int DIV_LSB    = 8;
  localparam int LOAD_BIT   = 16;
  localparam int EN_BIT     = 0;
  localparam int NUM_ROOT   = 4;
  localparam int CTL_STRIDE = 4;
  localparam int ROOT_UART  = 0;
  localparam int ROOT_I2C   = 1;
  localparam int ROOT_GMAC  = 2;
  localparam int ROOT_SPI   = 3;
  localparam logic [ADDR_W-1:0] CTL_BASE  = 12'h220;
  localparam logic [ADDR_W-1:0] PERI_ADDR = 12'h270;

  function automatic logic [ADDR_W-1:0] ctl_addr(input int k);
    return CTL_BASE + ADDR_W'(CTL_STRIDE * k);
  endfunction
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int PERI_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                we,
  output logic [DATA_W-1:0]   rdata,
  output logic [NUM_ROOT-1:0] en_sh,
  output logic [NUM_ROOT-1:0] ld_stb,
  output logic [DIV_W-1:0]    ld_val,
  output logic [PERI_W-1:0]   peri_sh
);
  logic [DIV_W-1:0]    div_sh [NUM_ROOT];
  logic [NUM_ROOT-1:0] hit;
  logic                peri_hit;
  logic [DATA_W-1:0]   rd_nx;
  logic                unused_wdata;

  assign unused_wdata = ^wdata;
  assign peri_hit     = (addr == PERI_ADDR);
  assign ld_val       = wdata[DIV_LSB +: DIV_W];

  always_comb begin
    for (int k = 0; k < NUM_ROOT; k++) begin
      hit[k]    = (addr == ctl_addr(k));
      ld_stb[k] = we & hit[k] & wdata[LOAD_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_ROOT; k++) begin
        div_sh[k] <= DIV_W'(1);
      end
      en_sh   <= '0;
      peri_sh <= '0;
    end else begin
      for (int k = 0; k < NUM_ROOT; k++) begin
        if (we && hit[k]) begin
          div_sh[k] <= wdata[DIV_LSB +: DIV_W];
          en_sh[k]  <= wdata[EN_BIT];
        end
      end
      if (we && peri_hit) peri_sh <= wdata[PERI_W-1:0];
    end
  end

  always_comb begin
    rd_nx = '0;
    for (int k = 0; k < NUM_ROOT; k++) begin
      if (hit[k]) begin
        rd_nx[DIV_LSB +: DIV_W] = div_sh[k];
        rd_nx[EN_BIT]           = en_sh[k];
      end
    end
    if (peri_hit) rd_nx[PERI_W-1:0] = peri_sh;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_nx;
  end
endmodule

// File: rtl/clkdiv_lane.sv
module clkdiv_lane #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_sh,
  input  logic             ld_stb,
  input  logic [DIV_W-1:0] ld_val,
  output logic             tick,
  output logic             bound,
  output logic             live
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] act;
  logic [DIV_W-1:0] pval;
  logic             pend;

  // act is never 0, so this marks the last cycle of the period
  assign bound = (cnt == act - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      act  <= DIV_W'(1);
      pval <= DIV_W'(1);
      pend <= 1'b0;
      live <= 1'b0;
      tick <= 1'b0;
    end else begin
      tick <= live & bound;
      if (ld_stb) begin
        pend <= 1'b1;
        pval <= ld_val;
      end else if (bound) begin
        pend <= 1'b0;
      end
      if (bound) begin
        cnt  <= '0;
        live <= en_sh;
        if (pend) act <= (pval == '0) ? DIV_W'(1) : pval;
      end else begin
        cnt <= cnt + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/clkdiv_gate.sv
module clkdiv_gate #(
  parameter int NUM = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bound,
  input  logic           live,
  input  logic [NUM-1:0] en_sh,
  output logic [NUM-1:0] tick
);
  logic [NUM-1:0] act;

  always_ff @(posedge clk) begin
    if (rst) begin
      act  <= '0;
      tick <= '0;
    end else begin
      tick <= act & {NUM{live & bound}};
      if (bound) act <= en_sh;
    end
  end
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int NUM_UART = 4,
  parameter int NUM_I2C  = 4,
  parameter int NUM_SPI  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_we,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [NUM_ROOT-1:0] root_tick,
  output logic [NUM_UART-1:0] uart_tick,
  output logic [NUM_I2C-1:0]  i2c_tick,
  output logic [NUM_SPI-1:0]  spi_tick
);
  localparam int PERI_W  = NUM_UART + NUM_I2C + NUM_SPI;
  localparam int I2C_LSB = NUM_UART;
  localparam int SPI_LSB = NUM_UART + NUM_I2C;

  logic [NUM_ROOT-1:0] en_sh, ld_stb, bound, live;
  logic [DIV_W-1:0]    ld_val;
  logic [PERI_W-1:0]   peri_sh;

  clkdiv_regs #(.PERI_W(PERI_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wdata(bus_wdata), .we(bus_we),
    .rdata(bus_rdata), .en_sh(en_sh), .ld_stb(ld_stb), .ld_val(ld_val),
    .peri_sh(peri_sh)
  );

  for (genvar k = 0; k < NUM_ROOT; k++) begin : g_lane
    clkdiv_lane #(.DIV_W(DIV_W)) u_lane (
      .clk(clk), .rst(rst), .en_sh(en_sh[k]), .ld_stb(ld_stb[k]),
      .ld_val(ld_val), .tick(root_tick[k]), .bound(bound[k]), .live(live[k])
    );
  end

  clkdiv_gate #(.NUM(NUM_UART)) u_uart_gate (
    .clk(clk), .rst(rst), .bound(bound[ROOT_UART]), .live(live[ROOT_UART]),
    .en_sh(peri_sh[NUM_UART-1:0]), .tick(uart_tick)
  );

  clkdiv_gate #(.NUM(NUM_I2C)) u_i2c_gate (
    .clk(clk), .rst(rst), .bound(bound[ROOT_I2C]), .live(live[ROOT_I2C]),
    .en_sh(peri_sh[I2C_LSB +: NUM_I2C]), .tick(i2c_tick)
  );

  clkdiv_gate #(.NUM(NUM_SPI)) u_spi_gate (
    .clk(clk), .rst(rst), .bound(bound[ROOT_SPI]), .live(live[ROOT_SPI]),
    .en_sh(peri_sh[SPI_LSB +: NUM_SPI]), .tick(spi_tick)
  );
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk
  import clkdiv_pkg::*;
#(
  parameter int NUM_UART = 4,
  parameter int NUM_I2C  = 4,
  parameter int NUM_SPI  = 2
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic                bus_we,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [NUM_ROOT-1:0] root_tick,
  input logic [NUM_UART-1:0] uart_tick,
  input logic [NUM_I2C-1:0]  i2c_tick,
  input logic [NUM_SPI-1:0]  spi_tick
);
  logic [1:0] cyc;
  logic       mapped;

  always_ff @(posedge clk) begin
    if (rst)            cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  always_comb begin
    mapped = (bus_addr == PERI_ADDR);
    for (int k = 0; k < NUM_ROOT; k++) begin
      if (bus_addr == ctl_addr(k)) mapped = 1'b1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (root_tick == '0 && uart_tick == '0 && i2c_tick == '0 && spi_tick == '0));

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc != 2'd0 && !$past(mapped)) |-> bus_rdata == '0);

  // R8
  uart_parent_chk: assert property (@(posedge clk) disable iff (rst)
    (|uart_tick) |-> root_tick[ROOT_UART]);

  // R8
  i2c_parent_chk: assert property (@(posedge clk) disable iff (rst)
    (|i2c_tick) |-> root_tick[ROOT_I2C]);

  // R8
  spi_parent_chk: assert property (@(posedge clk) disable iff (rst)
    (|spi_tick) |-> root_tick[ROOT_SPI]);

  // R2
  readback_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd2 && $past(bus_we, 2) && $past(bus_addr, 2) == CTL_BASE &&
     !$past(bus_we) && $past(bus_addr) == CTL_BASE)
    |-> (bus_rdata[DIV_LSB +: DIV_W] == $past(bus_wdata[DIV_LSB +: DIV_W], 2) &&
         bus_rdata[EN_BIT] == $past(bus_wdata[EN_BIT], 2) && !bus_rdata[LOAD_BIT]));
endmodule

bind clkdiv_bank clkdiv_bank_chk #(
  .NUM_UART(NUM_UART), .NUM_I2C(NUM_I2C), .NUM_SPI(NUM_SPI)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_rdata(bus_rdata), .root_tick(root_tick),
  .uart_tick(uart_tick), .i2c_tick(i2c_tick), .spi_tick(spi_tick)
);

// File: tb/tb_clkdiv_bank.sv
module tb_clkdiv_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [3:0]  root_tick;
  logic [3:0]  uart_tick;
  logic [3:0]  i2c_tick;
  logic [1:0]  spi_tick;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  clkdiv_bank dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .root_tick(root_tick),
    .uart_tick(uart_tick), .i2c_tick(i2c_tick), .spi_tick(spi_tick)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_cnt[4], m_act[4], m_live[4], m_pend[4], m_pval[4];
  int s_div[4], s_en[4], s_peri;
  int i_act[10];
  bit [3:0]  e_root;
  bit [9:0]  e_inst;
  bit [31:0] e_rd;

  function automatic int parent_of(input int i);
    if (i < 4) return 0;
    if (i < 8) return 1;
    return 3;
  endfunction

  function automatic bit [31:0] model_read(input int a);
    for (int k = 0; k < 4; k++)
      if (a == 'h220 + 4 * k) return 32'(s_div[k] * 256 + s_en[k]);
    if (a == 'h270) return 32'(s_peri);
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 4; k++) begin
        m_cnt[k] = 0; m_act[k] = 1; m_live[k] = 0; m_pend[k] = 0; m_pval[k] = 1;
        s_div[k] = 1; s_en[k] = 0;
      end
      for (int i = 0; i < 10; i++) i_act[i] = 0;
      s_peri = 0; e_root = '0; e_inst = '0; e_rd = '0;
    end else begin
      e_rd = model_read(int'(bus_addr));
      for (int k = 0; k < 4; k++) begin
        bit last;
        bit ld;
        int old_pend;
        int old_pval;
        last = (m_cnt[k] == m_act[k] - 1);
        e_root[k] = (m_live[k] != 0) && last;
        for (int i = 0; i < 10; i++)
          if (parent_of(i) == k) begin
            e_inst[i] = (i_act[i] != 0) && (m_live[k] != 0) && last;
            if (last) i_act[i] = (s_peri >> i) & 1;
          end
        old_pend = m_pend[k];
        old_pval = m_pval[k];
        ld = bus_we && (int'(bus_addr) == 'h220 + 4 * k) && bus_wdata[16];
        if (ld) begin
          m_pend[k] = 1; m_pval[k] = int'(bus_wdata[11:8]);
        end else if (last) begin
          m_pend[k] = 0;
        end
        if (last) begin
          m_cnt[k] = 0;
          m_live[k] = s_en[k];
          if (old_pend != 0) m_act[k] = (old_pval == 0) ? 1 : old_pval;
        end else begin
          m_cnt[k]++;
        end
      end
      if (bus_we) begin
        for (int k = 0; k < 4; k++)
          if (int'(bus_addr) == 'h220 + 4 * k) begin
            s_div[k] = int'(bus_wdata[11:8]); s_en[k] = int'(bus_wdata[0]);
          end
        if (int'(bus_addr) == 'h270) s_peri = int'(bus_wdata[9:0]);
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk(root_tick === e_root, "R3 R7 root strobe vs model", int'(root_tick), int'(e_root));
      chk({spi_tick, i2c_tick, uart_tick} === e_inst, "R8 instance strobe vs model",
          int'({spi_tick, i2c_tick, uart_tick}), int'(e_inst));
      chk(bus_rdata === e_rd, "R2 read data vs model", int'(bus_rdata), int'(e_rd));
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_addr = 12'(a); bus_wdata = 32'(d); bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 12'(a);
    @(negedge clk);
    chk(bus_rdata === 32'(exp), tag, int'(bus_rdata), exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // fam: 0 root, 1 uart, 2 i2c, 3 spi
  task automatic count(input int fam, input int idx, input int win, output int n);
    n = 0;
    repeat (win) begin
      @(negedge clk);
      case (fam)
        0: n += int'(root_tick[idx]);
        1: n += int'(uart_tick[idx]);
        2: n += int'(i2c_tick[idx]);
        default: n += int'(spi_tick[idx]);
      endcase
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    chk(root_tick == 0 && uart_tick == 0, "R1 strobes low after reset", int'(root_tick), 0);
    rd_chk('h220, 'h100, "R1 UART control reset");
    rd_chk('h224, 'h100, "R1 I2C control reset");
    rd_chk('h228, 'h100, "R1 GMAC control reset");
    rd_chk('h22C, 'h100, "R1 SPI control reset");
    rd_chk('h270, 0, "R1 peripheral enables reset");

    // R5 divisor without load: ratio stays 1
    wr('h220, 'h301);
    rd_chk('h220, 'h301, "R2 UART readback");
    idle(4);
    count(0, 0, 12, n);
    chk(n == 12, "R5 plain write keeps ratio", n, 12);

    // R6 load divisor 3
    wr('h220, 'h10301);
    rd_chk('h220, 'h301, "R2 load bit reads 0");
    idle(20);
    count(0, 0, 30, n);
    chk(n == 10, "R6 loaded divide-by-3", n, 10);

    // R6 change to 5
    wr('h220, 'h10501);
    idle(20);
    count(0, 0, 30, n);
    chk(n == 6, "R6 reloaded divide-by-5", n, 6);

    // R4 divisor 0
    wr('h224, 'h10001);
    idle(20);
    count(0, 1, 10, n);
    chk(n == 10, "R4 zero divisor as 1", n, 10);

    // R3 GMAC 7 and SPI 15
    wr('h228, 'h10701);
    wr('h22C, 'h10F01);
    rd_chk('h228, 'h701, "R2 GMAC readback");
    idle(20);
    count(0, 2, 28, n);
    chk(n == 4, "R3 divide-by-7", n, 4);
    count(0, 3, 30, n);
    chk(n == 2, "R3 divide-by-15", n, 2);

    // R7 disable UART root
    wr('h220, 'h500);
    idle(20);
    count(0, 0, 15, n);
    chk(n == 0, "R7 disabled root quiet", n, 0);

    // R8 instance gates
    wr('h270, 'h21A);
    wr('h220, 'h10301);
    idle(40);
    count(1, 1, 30, n);
    chk(n == 10, "R8 UART inst 1 on", n, 10);
    count(1, 0, 30, n);
    chk(n == 0, "R8 UART inst 0 off", n, 0);
    count(2, 0, 10, n);
    chk(n == 10, "R8 I2C inst 0 on", n, 10);
    count(3, 1, 30, n);
    chk(n == 2, "R8 SPI inst 1 on", n, 2);
    count(3, 0, 30, n);
    chk(n == 0, "R8 SPI inst 0 off", n, 0);

    // R9 unmapped accesses
    wr('h230, 'hFFFF_FFFF);
    wr('h271, 'hFFFF_FFFF);
    rd_chk('h230, 0, "R9 unmapped reads zero");
    rd_chk('h270, 'h21A, "R9 peripheral reg untouched");
    rd_chk('h224, 'h001, "R9 I2C control untouched");
    idle(10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule